// File: doc/BRIEF.md
# System Configuration Transaction Controller

This block sits on a simple 32-bit register bus and acts as a gateway to a small set of on-board configuration endpoints. Software first loads a shared data register and then writes a control word. The control word carries a go flag, a direction flag and a hierarchical endpoint address. The address has a device number, a position, a site, a function code and a board-controller index. One cycle after a control write with the go flag set, the block runs one transaction against the endpoint that matches the address.

The only endpoints built are programmable oscillators. Each oscillator holds a frequency in hertz and comes out of reset with its own default. A write transaction replaces the stored frequency with the data register. A read transaction copies the stored frequency into the data register. A control word that names no endpoint is dropped without side effects, and a status register reports that fact. Every oscillator frequency is also driven on a parallel output bus, so clock-consuming logic can follow it.

Top module: `sys_cfg_ctrl`

## Requirements
- R1: Register offsets on the bus are data 0xA0, control 0xA4 and status 0xA8. The control word fields are: bit 31 go, bit 30 write, bits 29:26 board controller, bits 25:20 function, bits 19:18 reserved, bits 17:16 site, bits 15:12 position, bits 11:0 device. Status bit 0 is done and bit 1 is error.
- R2: A control write with bit 31 clear starts no transaction. No oscillator changes and the status bits keep their values.
- R3: Matching compares all of control bits 29:0 against an endpoint key; bits 31:30 never take part. An endpoint key has function 1, board controller 0, position 0 and reserved bits 0.
- R4: A write transaction (bit 30 set) to a matched oscillator stores the current data register value into it.
- R5: A read transaction (bit 30 clear) to a matched oscillator loads its frequency into the data register.
- R6: A transaction whose address matches no endpoint leaves the data register and all oscillators unchanged and sets status error. This covers every function code other than 1.
- R7: After reset the data register is 0, status is 0 and the oscillators hold these values in hertz. Site 0: device 0 is 50000000, device 1 is 23750000, device 2 is 24000000, device 4 is 24000000. Site 1: device 0 is 60000000, device 4 is 40000000, device 5 is 23750000, device 6 is 50000000, device 7 is 60000000, device 8 is 40000000.
- R8: A control write with go set clears both status bits at its clock edge. Status done becomes 1 at the following edge, when the transaction takes effect.
- R9: A write transaction that carries frequency 0 leaves the oscillator unchanged and ends with done 1 and error 0. A stored frequency is never 0.
- R10: Output `osc_freq` carries oscillator k on bits 32k+31:32k. The index order is site 0 devices 0, 1, 2, 4, then site 1 devices 0, 4, 5, 6, 7, 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Access is a write when set |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| osc_freq | output | 320 | All oscillator frequencies, 32 bits each |

## Verification
The assertions assume that software does not write the data register in the same cycle as a read transaction loads it. The assertions on status done also assume that no second go write lands in the cycle in which the first transaction executes. The bench keeps within both assumptions. Every access is a separate task call that leaves at least one idle cycle after each control write, and every check waits until the transaction edge has passed.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

    localparam int WORD_W  = 32;
    localparam int KEY_W   = 30;
    localparam int NUM_OSC = 10;
    localparam logic [5:0] FN_OSC = 6'd1;

    typedef struct packed {
        logic        go;
        logic        is_wr;
        logic [3:0]  board_ctl;
        logic [5:0]  fn;
        logic [1:0]  rsvd;
        logic [1:0]  site;
        logic [3:0]  pos;
        logic [11:0] dev;
    } ctrl_word_t;

    typedef struct packed {
        logic             is_wr;
        logic [KEY_W-1:0] key;
    } xact_t;

    typedef enum logic [1:0] {SEL_DATA, SEL_CTRL, SEL_STAT, SEL_NONE} reg_sel_t;

    function automatic logic [1:0] osc_site(input int idx);
        return (idx < 4) ? 2'd0 : 2'd1;
    endfunction

    function automatic logic [11:0] osc_dev(input int idx);
        case (idx)
            0: return 12'd0;
            1: return 12'd1;
            2: return 12'd2;
            3: return 12'd4;
            4: return 12'd0;
            5: return 12'd4;
            6: return 12'd5;
            7: return 12'd6;
            8: return 12'd7;
            default: return 12'd8;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] osc_reset_hz(input int idx);
        case (idx)
            0: return 32'd50000000;
            1: return 32'd23750000;
            2: return 32'd24000000;
            3: return 32'd24000000;
            4: return 32'd60000000;
            5: return 32'd40000000;
            6: return 32'd23750000;
            7: return 32'd50000000;
            8: return 32'd60000000;
            default: return 32'd40000000;
        endcase
    endfunction

    function automatic logic [KEY_W-1:0] osc_key(input int idx);
        ctrl_word_t w;
        logic [WORD_W-1:0] raw;
        w      = '0;
        w.fn   = FN_OSC;
        w.site = osc_site(idx);
        w.dev  = osc_dev(idx);
        raw    = w;
        return raw[KEY_W-1:0];
    endfunction

endpackage

// File: rtl/cfg_host_regs.sv
module cfg_host_regs
    import cfgbus_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int OFF_DATA = 'hA0,
    parameter int OFF_CTRL = 'hA4,
    parameter int OFF_STAT = 'hA8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              hit,
    input  logic [WORD_W-1:0] rd_val,
    output logic              ctrl_wr,
    output logic              data_wr,
    output logic              pend,
    output xact_t             xact,
    output logic [WORD_W-1:0] data_q,
    output logic              done,
    output logic              err
);

    reg_sel_t   sel;
    ctrl_word_t wword;

    always_comb begin
        if (bus_addr == ADDR_W'(OFF_DATA))      sel = SEL_DATA;
        else if (bus_addr == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
        else if (bus_addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
        else                                    sel = SEL_NONE;
    end

    assign wword   = bus_wdata;
    assign ctrl_wr = bus_en && bus_we && (sel == SEL_CTRL);
    assign data_wr = bus_en && bus_we && (sel == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            xact   <= '0;
            pend   <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            pend <= ctrl_wr && wword.go;
            if (data_wr) data_q <= bus_wdata;
            if (ctrl_wr) xact <= {wword.is_wr, bus_wdata[KEY_W-1:0]};
            if (pend) begin
                done <= 1'b1;
                err  <= !hit;
                if (!xact.is_wr && hit) data_q <= rd_val;
            end
            if (ctrl_wr && wword.go) begin
                done <= 1'b0;
                err  <= 1'b0;
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: bus_rdata = {1'b0, xact};
            SEL_STAT: bus_rdata = {{(WORD_W-2){1'b0}}, err, done};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfg_addr_match.sv
module cfg_addr_match
    import cfgbus_pkg::*;
#(
    parameter int NUM = NUM_OSC
) (
    input  logic [KEY_W-1:0] key,
    output logic [NUM-1:0]   hit_vec,
    output logic             hit
);

    for (genvar i = 0; i < NUM; i++) begin : g_cmp
        localparam logic [KEY_W-1:0] EP_KEY = osc_key(i);
        assign hit_vec[i] = (key == EP_KEY);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/cfg_osc_bank.sv
module cfg_osc_bank
    import cfgbus_pkg::*;
#(
    parameter int NUM = NUM_OSC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                do_wr,
    input  logic [NUM-1:0]      sel_vec,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rd_val,
    output logic [NUM*WORD_W-1:0] freq_flat
);

    logic [WORD_W-1:0] freq [NUM];
    logic              nonzero;

    assign nonzero = (wdata != '0);

    for (genvar i = 0; i < NUM; i++) begin : g_osc
        localparam logic [WORD_W-1:0] RST_HZ = osc_reset_hz(i);
        always_ff @(posedge clk) begin
            if (rst)                               freq[i] <= RST_HZ;
            else if (do_wr && sel_vec[i] && nonzero) freq[i] <= wdata;
        end
        assign freq_flat[i*WORD_W +: WORD_W] = freq[i];
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM; i++) begin
            if (sel_vec[i]) rd_val = rd_val | freq[i];
        end
    end

endmodule

// File: rtl/sys_cfg_ctrl.sv
module sys_cfg_ctrl
    import cfgbus_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int OFF_DATA = 'hA0,
    parameter int OFF_CTRL = 'hA4,
    parameter int OFF_STAT = 'hA8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_en,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [WORD_W-1:0]         bus_wdata,
    output logic [WORD_W-1:0]         bus_rdata,
    output logic [NUM_OSC*WORD_W-1:0] osc_freq
);

    logic              ctrl_wr, data_wr, pend, hit, done, err;
    xact_t             xact;
    logic [WORD_W-1:0] data_q, rd_val;
    logic [NUM_OSC-1:0] hit_vec;

    cfg_host_regs #(
        .ADDR_W(ADDR_W), .OFF_DATA(OFF_DATA),
        .OFF_CTRL(OFF_CTRL), .OFF_STAT(OFF_STAT)
    ) u_regs (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hit(hit), .rd_val(rd_val), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
        .pend(pend), .xact(xact), .data_q(data_q), .done(done), .err(err)
    );

    cfg_addr_match #(.NUM(NUM_OSC)) u_match (
        .key(xact.key), .hit_vec(hit_vec), .hit(hit)
    );

    cfg_osc_bank #(.NUM(NUM_OSC)) u_osc (
        .clk(clk), .rst(rst), .do_wr(pend && xact.is_wr),
        .sel_vec(hit_vec), .wdata(data_q), .rd_val(rd_val),
        .freq_flat(osc_freq)
    );

endmodule

// File: rtl/cfg_ctrl_checker.sv
module cfg_ctrl_checker
    import cfgbus_pkg::*;
#(
    parameter int NUM = NUM_OSC
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ctrl_wr,
    input logic                  go,
    input logic                  data_wr,
    input logic                  pend,
    input logic                  xact_wr,
    input logic                  hit,
    input logic [NUM-1:0]        hit_vec,
    input logic [WORD_W-1:0]     rd_val,
    input logic [WORD_W-1:0]     data_q,
    input logic                  done,
    input logic                  err,
    input logic [NUM*WORD_W-1:0] osc_freq
);

    p_nostart_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && !go |=> ##1 $stable(osc_freq));

    p_single_match_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_read_loads_r5: assert property (@(posedge clk) disable iff (rst)
        pend && !xact_wr && hit |=> data_q == $past(rd_val));

    p_unknown_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        pend && !hit && !data_wr |=> $stable(data_q) && err);

    p_clear_on_go_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && go |=> !done && !err);

    p_done_next_r8: assert property (@(posedge clk) disable iff (rst)
        pend && !(ctrl_wr && go) |=> done);

    for (genvar i = 0; i < NUM; i++) begin : g_osc_chk
        p_write_stores_r4: assert property (@(posedge clk) disable iff (rst)
            pend && xact_wr && hit_vec[i] && data_q != '0
            |=> osc_freq[i*WORD_W +: WORD_W] == $past(data_q));

        p_never_zero_r9: assert property (@(posedge clk) disable iff (rst)
            osc_freq[i*WORD_W +: WORD_W] != '0);
    end

endmodule

bind sys_cfg_ctrl cfg_ctrl_checker #(.NUM(cfgbus_pkg::NUM_OSC)) u_chk (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .go(bus_wdata[31]),
    .data_wr(data_wr), .pend(pend), .xact_wr(xact.is_wr), .hit(hit),
    .hit_vec(hit_vec), .rd_val(rd_val), .data_q(data_q), .done(done),
    .err(err), .osc_freq(osc_freq)
);

// File: tb/tb_sys_cfg_ctrl.sv
module tb_sys_cfg_ctrl;

    localparam int NOSC = 10;
    localparam logic [7:0] A_DATA = 8'hA0;
    localparam logic [7:0] A_CTRL = 8'hA4;
    localparam logic [7:0] A_STAT = 8'hA8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NOSC*32-1:0] osc_freq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int          m_site [NOSC] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
    int          m_dev  [NOSC] = '{0, 1, 2, 4, 0, 4, 5, 6, 7, 8};
    logic [31:0] m_hz   [NOSC] = '{32'd50000000, 32'd23750000, 32'd24000000,
                                   32'd24000000, 32'd60000000, 32'd40000000,
                                   32'd23750000, 32'd50000000, 32'd60000000,
                                   32'd40000000};

    sys_cfg_ctrl dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .osc_freq(osc_freq)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input bit go, input bit wr,
        input int board, input int fn, input int rsvd, input int site,
        input int pos, input int dev);
        return {go, wr, 4'(board), 6'(fn), 2'(rsvd), 2'(site), 4'(pos), 12'(dev)};
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_xact(input logic [31:0] ctrl);
        bus_write(A_CTRL, ctrl);
        @(negedge clk);
    endtask

    task automatic check_all_osc(input string req);
        for (int k = 0; k < NOSC; k++)
            check(osc_freq[k*32 +: 32] == m_hz[k], req, osc_freq[k*32 +: 32], m_hz[k]);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bus_read(A_DATA, v); check(v == 0, "R7 data reset", v, 0);
        bus_read(A_STAT, v); check(v == 0, "R7 status reset", v, 0);
        check_all_osc("R7/R10 reset frequency");
    endtask

    task automatic t_read_all;
        logic [31:0] v;
        for (int k = 0; k < NOSC; k++) begin
            run_xact(mk_ctrl(1, 0, 0, 1, 0, m_site[k], 0, m_dev[k]));
            bus_read(A_DATA, v); check(v == m_hz[k], "R5 read oscillator", v, m_hz[k]);
            bus_read(A_STAT, v); check(v == 1, "R1 status done", v, 1);
        end
    endtask

    task automatic t_write;
        logic [31:0] v;
        bus_write(A_DATA, 32'd12345678);
        run_xact(mk_ctrl(1, 1, 0, 1, 0, 1, 0, 5));
        m_hz[6] = 32'd12345678;
        check_all_osc("R4 write oscillator");
        bus_write(A_DATA, 32'd0);
        run_xact(mk_ctrl(1, 0, 0, 1, 0, 1, 0, 5));
        bus_read(A_DATA, v); check(v == 32'd12345678, "R4 readback", v, 32'd12345678);
    endtask

    task automatic t_no_start;
        logic [31:0] v, s0;
        bus_read(A_STAT, s0);
        bus_write(A_DATA, 32'h0BAD_0001);
        run_xact(mk_ctrl(0, 1, 0, 1, 0, 0, 0, 1));
        @(negedge clk);
        check_all_osc("R2 no go no write");
        bus_read(A_STAT, v); check(v == s0, "R2 status kept", v, s0);
    endtask

    task automatic t_unknown;
        logic [31:0] v;
        bus_write(A_DATA, 32'hCAFE_0042);
        run_xact(mk_ctrl(1, 0, 0, 2, 0, 0, 0, 0));
        bus_read(A_DATA, v); check(v == 32'hCAFE_0042, "R6 data kept on fn 2", v, 32'hCAFE_0042);
        bus_read(A_STAT, v); check(v == 3, "R6 error set", v, 3);
        run_xact(mk_ctrl(1, 1, 0, 7, 0, 1, 0, 0));
        check_all_osc("R6 fn 7 write dropped");
        run_xact(mk_ctrl(1, 1, 0, 1, 0, 0, 0, 3));
        check_all_osc("R6 absent device write dropped");
        bus_read(A_STAT, v); check(v == 3, "R6 absent device error", v, 3);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        bus_write(A_DATA, 32'h1111_2222);
        run_xact(mk_ctrl(1, 1, 0, 1, 1, 0, 0, 0));
        check_all_osc("R3 reserved bits block match");
        run_xact(mk_ctrl(1, 1, 0, 1, 0, 0, 2, 0));
        check_all_osc("R3 position blocks match");
        run_xact(mk_ctrl(1, 1, 3, 1, 0, 0, 0, 0));
        check_all_osc("R3 board controller blocks match");
        bus_read(A_STAT, v); check(v == 3, "R3 mismatch error", v, 3);
        run_xact(mk_ctrl(1, 1, 0, 1, 0, 0, 0, 0));
        m_hz[0] = 32'h1111_2222;
        check_all_osc("R3 flags excluded from match");
    endtask

    task automatic t_status_timing;
        logic [31:0] v;
        run_xact(mk_ctrl(1, 0, 0, 9, 0, 0, 0, 0));
        bus_read(A_STAT, v); check(v == 3, "R8 error before go", v, 3);
        bus_write(A_CTRL, mk_ctrl(1, 0, 0, 1, 0, 0, 0, 2));
        bus_read(A_STAT, v); check(v == 0, "R8 cleared at go edge", v, 0);
        @(negedge clk);
        bus_read(A_STAT, v); check(v == 1, "R8 done next edge", v, 1);
        bus_read(A_DATA, v); check(v == m_hz[2], "R8 data ready", v, m_hz[2]);
    endtask

    task automatic t_zero;
        logic [31:0] v;
        bus_write(A_DATA, 32'd0);
        run_xact(mk_ctrl(1, 1, 0, 1, 0, 1, 0, 8));
        check_all_osc("R9 zero write ignored");
        bus_read(A_STAT, v); check(v == 1, "R9 done without error", v, 1);
    endtask

    task automatic t_regmap;
        logic [31:0] v, c;
        c = mk_ctrl(0, 1, 5, 1, 0, 1, 0, 4);
        bus_write(A_CTRL, c);
        bus_read(A_CTRL, v); check(v == c, "R1 control readback", v, c);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_read_all;
        t_write;
        t_no_start;
        t_unknown;
        t_mask;
        t_status_timing;
        t_zero;
        t_regmap;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule